// File: doc/BRIEF.md
# Ring Command Sequencer with Retry

This block is the central scheduler of a ring of image-analysis modules. A small frame memory, filled over a write port before a run, holds every 6-byte command frame the run needs. After a start pulse the sequencer sends the seven setup frames for the image pair once. It then walks the per-window frames of all processing modules, interleaving the modules step by step, and repeats that pass a fixed number of times.

Only one command is in flight at any time. Each command is followed straight away by one empty frame, which a module may fill with a result. The sequencer then waits for its own command to come back round the ring and reads the status byte. An executed status moves the schedule on. An error status resends the same frame, up to a limit, and past that limit a reinitialise pulse is raised. A frame that returns without either flag is simply resent.

Returned frames addressed to the sequencer itself carry results. They are streamed out byte by byte on a valid/ready host port.

Top module: `ring_cmd_seq`

## Requirements
- R1: While reset is asserted and after its release, `tx_valid`, `host_valid`, `done` and `reinit` are low, and no frame is sent until `start` is pulsed.
- R2: A frame written through `mem_we`/`mem_waddr`/`mem_wdata` is sent unchanged on `tx_frame` when the schedule reaches that index.
- R3: The schedule sends indices 0 to 6 once. It then sends index 7+4·m+s for step s = 0..3 (outer loop) and module m = 0..NUM_PM-1 (inner loop), and repeats that pass NUM_ROUNDS times. After the last command executes, `done` pulses for one cycle.
- R4: Every accepted command frame is followed in the next cycle by one empty frame, which is all zeros, address field 0.
- R5: No new command is issued until the outstanding one has returned. The frame layout is: address in bits 47:44, command in 43:40, four info bytes, status in bits 7:0. In the status byte, bit 0 is error, bit 1 is busy, bit 2 is received and bit 3 is executed.
- R6: A returned command with the error bit set is reissued unchanged, up to MAX_RETRY (3) times. The count clears when a command executes.
- R7: The next error after MAX_RETRY resends gives a one-cycle `reinit` pulse and a return to idle, and no further frame is sent.
- R8: A returned command with neither the error bit nor the executed bit set is reissued without counting toward the retry limit.
- R9: A returned frame with address 0 (an unused empty frame) is ignored, whatever its status.
- R10: A returned frame with address CTRL_ADDR (1) is sent on the host port as 6 bytes, bits 47:40 first. Each byte is held stable while `host_ready` is low.
- R11: A result frame that arrives while the host port is still sending an earlier one is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| mem_we | input | 1 | Frame memory write enable |
| mem_waddr | input | IDX_W | Frame memory write index |
| mem_wdata | input | 48 | Frame to store |
| tx_valid | output | 1 | Frame offered to the ring |
| tx_ready | input | 1 | Ring accepts the offered frame |
| tx_frame | output | 48 | Frame sent on the ring |
| rx_valid | input | 1 | Frame returning from the ring |
| rx_frame | input | 48 | Returning frame |
| host_valid | output | 1 | Result byte available |
| host_ready | input | 1 | Host takes the byte |
| host_data | output | 8 | Result byte |
| done | output | 1 | One-cycle pulse at schedule end |
| reinit | output | 1 | One-cycle pulse when retries run out |

## Verification
A command frame appears in the cycle after `start`, or after the decision edge. Its empty frame follows one cycle after the command is accepted. A returned frame is captured at one edge and judged at the next, so the next command, `done` or `reinit` is visible right after that second edge. A result frame's first byte is visible right after the edge that samples it. The bench drives all inputs on falling edges and waits the exact number of falling edges those latencies give before it samples the outputs.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;
  localparam int FRAME_W  = 48;
  localparam int CFG_N    = 7;
  localparam int STEPS    = 4;
  localparam int ST_ERR   = 0;
  localparam int ST_EXEC  = 3;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_PAD,
    S_WAIT
  } seq_state_e;
endpackage

// File: rtl/rseq_frame_mem.sv
module rseq_frame_mem #(
  parameter int DEPTH = 15,
  parameter int AW    = 4,
  parameter int W     = 48
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/rseq_index_gen.sv
module rseq_index_gen
  import ring_seq_pkg::*;
#(
  parameter int NPM    = 2,
  parameter int ROUNDS = 2,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  output logic [AW-1:0] idx,
  output logic          last
);
  localparam int MW = (NPM > 1) ? $clog2(NPM) : 1;
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  logic          win_q, win_n;
  logic [2:0]    cfg_q, cfg_n;
  logic [1:0]    step_q, step_n;
  logic [MW-1:0] mod_q, mod_n;
  logic [RW-1:0] rnd_q, rnd_n;

  always_comb begin
    win_n  = win_q;
    cfg_n  = cfg_q;
    step_n = step_q;
    mod_n  = mod_q;
    rnd_n  = rnd_q;
    if (restart) begin
      win_n  = 1'b0;
      cfg_n  = '0;
      step_n = '0;
      mod_n  = '0;
      rnd_n  = '0;
    end else if (advance) begin
      if (!win_q) begin
        if (cfg_q == 3'(CFG_N - 1)) win_n = 1'b1;
        else                        cfg_n = cfg_q + 3'd1;
      end else if (mod_q == MW'(NPM - 1)) begin
        mod_n = '0;
        if (step_q == 2'(STEPS - 1)) begin
          step_n = '0;
          rnd_n  = (rnd_q == RW'(ROUNDS - 1)) ? '0 : rnd_q + RW'(1);
        end else begin
          step_n = step_q + 2'd1;
        end
      end else begin
        mod_n = mod_q + MW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      cfg_q  <= '0;
      step_q <= '0;
      mod_q  <= '0;
      rnd_q  <= '0;
    end else if (restart || advance) begin
      win_q  <= win_n;
      cfg_q  <= cfg_n;
      step_q <= step_n;
      mod_q  <= mod_n;
      rnd_q  <= rnd_n;
    end
  end

  // window frames: module m, step s lives at CFG_N + STEPS*m + s
  assign idx  = win_q ? AW'(CFG_N + STEPS * int'(mod_q) + int'(step_q)) : AW'(cfg_q);
  assign last = win_q && (mod_q == MW'(NPM - 1)) && (step_q == 2'(STEPS - 1)) &&
                (rnd_q == RW'(ROUNDS - 1));
endmodule

// File: rtl/rseq_host_ser.sv
module rseq_host_ser
  import ring_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               host_valid,
  input  logic               host_ready,
  output logic [7:0]         host_data
);
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [2:0]         cnt_q, cnt_n;
  logic               busy_n;
  logic               en;

  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    busy_n = busy;
    if (!busy && load) begin
      sh_n   = frame;
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (busy && host_ready) begin
      sh_n  = {sh_q[FRAME_W-9:0], 8'h00};
      cnt_n = cnt_q + 3'd1;
      if (cnt_q == 3'd5) busy_n = 1'b0;
    end
  end

  assign en = (!busy && load) || (busy && host_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (en) begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      busy  <= busy_n;
    end
  end

  assign host_valid = busy;
  assign host_data  = sh_q[FRAME_W-1 -: 8];
endmodule

// File: rtl/ring_cmd_seq.sv
module ring_cmd_seq
  import ring_seq_pkg::*;
#(
  parameter int          NUM_PM     = 2,
  parameter int          NUM_ROUNDS = 2,
  parameter int          MAX_RETRY  = 3,
  parameter logic [3:0]  CTRL_ADDR  = 4'h1,
  parameter int          FRAMES     = CFG_N + STEPS * NUM_PM,
  parameter int          IDX_W      = $clog2(FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mem_we,
  input  logic [IDX_W-1:0]   mem_waddr,
  input  logic [FRAME_W-1:0] mem_wdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [FRAME_W-1:0] tx_frame,
  input  logic               rx_valid,
  input  logic [FRAME_W-1:0] rx_frame,
  output logic               host_valid,
  input  logic               host_ready,
  output logic [7:0]         host_data,
  output logic               done,
  output logic               reinit
);
  localparam int RTW = $clog2(MAX_RETRY + 1);

  seq_state_e         st_q, st_n;
  logic [RTW-1:0]     rty_q, rty_n;
  logic               pend_q, pend_n;
  logic               rerr_q, rerr_n;
  logic               rexe_q, rexe_n;
  logic               done_n, reinit_n;
  logic               restart, advance, last;
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] mem_rd;
  logic               ser_busy;
  logic [3:0]         rx_addr;
  logic               rx_is_ret, rx_is_res, cap;

  rseq_frame_mem #(.DEPTH(FRAMES), .AW(IDX_W), .W(FRAME_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(idx),
    .rdata(mem_rd)
  );

  rseq_index_gen #(.NPM(NUM_PM), .ROUNDS(NUM_ROUNDS), .AW(IDX_W)) u_idx (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .advance(advance),
    .idx    (idx),
    .last   (last)
  );

  assign rx_addr   = rx_frame[FRAME_W-1 -: 4];
  assign rx_is_res = rx_valid && (rx_addr == CTRL_ADDR);
  assign rx_is_ret = rx_valid && (rx_addr != 4'h0) && (rx_addr != CTRL_ADDR);
  assign cap       = rx_is_ret && ((st_q == S_PAD) || (st_q == S_WAIT));

  rseq_host_ser u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rx_is_res),
    .frame     (rx_frame),
    .busy      (ser_busy),
    .host_valid(host_valid),
    .host_ready(host_ready),
    .host_data (host_data)
  );

  always_comb begin
    st_n     = st_q;
    rty_n    = rty_q;
    pend_n   = pend_q;
    rerr_n   = rerr_q;
    rexe_n   = rexe_q;
    done_n   = 1'b0;
    reinit_n = 1'b0;
    restart  = 1'b0;
    advance  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        pend_n = 1'b0;
        if (start) begin
          restart = 1'b1;
          rty_n   = '0;
          st_n    = S_ISSUE;
        end
      end
      S_ISSUE: if (tx_ready) st_n = S_PAD;
      S_PAD:   if (tx_ready) st_n = S_WAIT;
      S_WAIT: begin
        if (pend_q) begin
          pend_n = 1'b0;
          if (rerr_q) begin
            if (rty_q == RTW'(MAX_RETRY)) begin
              reinit_n = 1'b1;
              st_n     = S_IDLE;
            end else begin
              rty_n = rty_q + RTW'(1);
              st_n  = S_ISSUE;
            end
          end else if (rexe_q) begin
            rty_n = '0;
            if (last) begin
              done_n = 1'b1;
              st_n   = S_IDLE;
            end else begin
              advance = 1'b1;
              st_n    = S_ISSUE;
            end
          end else begin
            st_n = S_ISSUE;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (cap) begin
      pend_n = 1'b1;
      rerr_n = rx_frame[ST_ERR];
      rexe_n = rx_frame[ST_EXEC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rty_q  <= '0;
      pend_q <= 1'b0;
      rerr_q <= 1'b0;
      rexe_q <= 1'b0;
      done   <= 1'b0;
      reinit <= 1'b0;
    end else begin
      st_q   <= st_n;
      rty_q  <= rty_n;
      pend_q <= pend_n;
      done   <= done_n;
      reinit <= reinit_n;
      if (cap) begin
        rerr_q <= rerr_n;
        rexe_q <= rexe_n;
      end
    end
  end

  assign tx_valid = (st_q == S_ISSUE) || (st_q == S_PAD);
  assign tx_frame = (st_q == S_ISSUE) ? mem_rd : '0;
endmodule

// File: rtl/ring_cmd_seq_chk.sv
module ring_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [47:0] tx_frame,
  input logic        host_valid,
  input logic        host_ready,
  input logic [7:0]  host_data,
  input logic        done,
  input logic        reinit
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!tx_valid && !host_valid && !done && !reinit)
        else $error("R1 outputs active in reset");
    end
  end

  a_r4_empty_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && (tx_frame[47:44] != 4'h0)) |=> (tx_valid && (tx_frame == '0)))
    else $error("R4 no empty frame after command");

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_frame)))
    else $error("R5 frame changed while stalled");

  a_r10_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_ready) |=> (host_valid && $stable(host_data)))
    else $error("R10 host byte changed while stalled");

  a_r7_reinit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (!tx_valid && !reinit))
    else $error("R7 activity after reinit");

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !tx_valid))
    else $error("R3 done not a single pulse");

  a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && reinit))
    else $error("R7 done and reinit together");
endmodule

bind ring_cmd_seq ring_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_frame  (tx_frame),
  .host_valid(host_valid),
  .host_ready(host_ready),
  .host_data (host_data),
  .done      (done),
  .reinit    (reinit)
);

// File: tb/ring_cmd_seq_tb.sv
module ring_cmd_seq_tb;
  localparam int NPM  = 2;
  localparam int RNDS = 2;
  localparam int NF   = 7 + 4 * NPM;
  localparam int NCMD = 7 + 4 * NPM * RNDS;
  localparam int AW   = $clog2(NF);
  // status codes per return: executed=08, error=01, busy=02
  localparam logic [7:0] RESP [12] = '{8'h08, 8'h01, 8'h01, 8'h01, 8'h08, 8'h01,
                                       8'h01, 8'h01, 8'h08, 8'h02, 8'h08, 8'h0C};

  logic          clk = 1'b0;
  logic          rst_n, start, mem_we, tx_ready, rx_valid, host_ready;
  logic [AW-1:0] mem_waddr;
  logic [47:0]   mem_wdata, rx_frame, tx_frame;
  logic          tx_valid, host_valid, done, reinit;
  logic [7:0]    host_data;

  int total = 0;
  int bad   = 0;
  int expseq [NCMD];

  always #10 clk = ~clk;

  ring_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_frame(tx_frame),
    .rx_valid(rx_valid), .rx_frame(rx_frame),
    .host_valid(host_valid), .host_ready(host_ready), .host_data(host_data),
    .done(done), .reinit(reinit)
  );

  function automatic logic [47:0] frame_of(int i);
    logic [7:0] b = 8'(i);
    return {4'(2 + i % 13), 4'(i), b, ~b, b + 8'h40, 8'hA5, 8'h00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tx(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (tx_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic ret(input logic [47:0] f);
    rx_frame = f;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit         seen;
    int         k, t;
    logic [7:0] st, prev;
    logic [47:0] cur;
    logic [47:0] res_a;

    for (int c = 0; c < 7; c++) expseq[c] = c;
    k = 7;
    for (int r = 0; r < RNDS; r++)
      for (int s = 0; s < 4; s++)
        for (int m = 0; m < NPM; m++) begin
          expseq[k] = 7 + 4 * m + s;
          k++;
        end

    rst_n = 1'b0; start = 1'b0; mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    tx_ready = 1'b1; rx_valid = 1'b0; rx_frame = '0; host_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !host_valid && !done && !reinit, "R1 reset", {tx_valid, host_valid, done, reinit}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NF; i++) begin
      mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = frame_of(i);
      @(negedge clk);
    end
    mem_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R1 idle before start", tx_valid, 0);

    // table-driven main schedule
    pulse_start();
    k = 0; t = 0; prev = 8'h08;
    while (k < NCMD) begin
      wait_tx(seen);
      chk(seen, "R5 command issued", seen, 1);
      if (!seen) break;
      chk(tx_frame == frame_of(expseq[k]),
          prev[0] ? "R6 resend" : (!prev[3] ? "R8 resend" : "R2 R3 order"),
          tx_frame, frame_of(expseq[k]));
      cur = tx_frame;
      @(negedge clk);
      chk(tx_valid && tx_frame == '0, "R4 empty frame", tx_frame, 0);
      @(negedge clk);
      chk(!tx_valid, "R5 wait for return", tx_valid, 0);
      st = RESP[t % 12]; t++;
      ret({cur[47:8], st});
      prev = st;
      if (st[3] && !st[0]) k++;
    end
    @(negedge clk);
    chk(done && !tx_valid, "R3 done pulse", {done, tx_valid}, 2'b10);
    @(negedge clk);
    chk(!done && !tx_valid, "R3 done ends", {done, tx_valid}, 0);

    // returned empty frame ignored
    pulse_start();
    wait_tx(seen);
    chk(tx_frame == frame_of(0), "R3 restart at 0", tx_frame, frame_of(0));
    cur = tx_frame;
    repeat (2) @(negedge clk);
    ret({4'h0, 36'h0, 8'h01});
    repeat (2) @(negedge clk);
    chk(!tx_valid && !host_valid, "R9 empty ignored", {tx_valid, host_valid}, 0);
    ret({cur[47:8], 8'h08});
    wait_tx(seen);
    chk(tx_frame == frame_of(1), "R9 advance after real return", tx_frame, frame_of(1));

    // retry exhaustion
    do_reset();
    pulse_start();
    for (int e = 0; e < 4; e++) begin
      wait_tx(seen);
      chk(seen && tx_frame == frame_of(0), "R6 same command", tx_frame, frame_of(0));
      cur = tx_frame;
      repeat (2) @(negedge clk);
      ret({cur[47:8], 8'h05});
    end
    @(negedge clk);
    chk(reinit && !tx_valid, "R7 reinit pulse", {reinit, tx_valid}, 2'b10);
    @(negedge clk);
    chk(!reinit, "R7 reinit one cycle", reinit, 0);
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R7 no traffic", tx_valid, 0);

    // host forwarding and drop
    res_a = {4'h1, 4'h7, 32'h11223344, 8'h08};
    host_ready = 1'b0;
    rx_frame = res_a; rx_valid = 1'b1;
    @(negedge clk);
    rx_frame = {4'h1, 4'h9, 32'hDEADBEEF, 8'h08};
    @(negedge clk);
    rx_valid = 1'b0;
    chk(host_valid && host_data == 8'h17, "R10 first byte", host_data, 8'h17);
    @(negedge clk);
    chk(host_valid && host_data == 8'h17, "R10 held while not ready", host_data, 8'h17);
    host_ready = 1'b1;
    for (int b = 0; b < 6; b++) begin
      chk(host_valid && host_data == res_a[47 - 8 * b -: 8], "R10 byte order",
          host_data, res_a[47 - 8 * b -: 8]);
      @(negedge clk);
    end
    chk(!host_valid, "R11 second result dropped", host_valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule